// File: doc/BRIEF.md
# DMA Channel Enable Register Bank

This block is the software-visible control store for a DMA engine with up to 64 channels. It keeps two per-channel vectors: a request-enable vector, which the engine reads to decide which hardware requests it may serve, and an error-interrupt-enable vector. Software reads and writes each vector as two 32-bit halves over a simple synchronous register bus.

A write-only command register accepts a channel number instead of a bitmask. It can turn on a single request-enable bit without a read-modify-write sequence, or turn on every implemented bit at once. The block also gates the engine's per-channel error flags with the error-interrupt-enable vector. It drives one interrupt request per channel and an aggregate request. The error flags belong to the engine, and this block never clears them.

Top module: `dma_en_bank`

## Requirements
- R1: After reset, both vectors are all zeros, `req_en_o` is zero and `rdata_o` is zero.
- R2: The request-enable vector is read/write at offset 0x08 (bit i = channel 32+i) and offset 0x0C (bit i = channel i).
- R3: The error-interrupt-enable vector is read/write at offset 0x10 (bit i = channel 32+i) and offset 0x14 (bit i = channel i).
- R4: A write to the command offset 0x18 uses only `wdata_i[7:0]`. A byte value n in 0..63 sets request-enable bit n and leaves every other bit unchanged.
- R5: A command byte in 64..127 sets every implemented request-enable bit.
- R6: A command byte with bit 7 set (128..255) changes no state.
- R7: A read of the command offset returns zero.
- R8: `err_irq_o[n]` is 1 exactly when `err_flag_i[n]` and error-interrupt-enable bit n are both 1, with no clock delay.
- R9: `err_irq_any_o` is the OR of all bits of `err_irq_o`.
- R10: A read of any other offset returns zero, and a write to it changes no state.
- R11: Bits for channels at or above `NUM_CH` read as zero and cannot be set, either by a direct write or by a command.
- R12: `rdata_o` presents the addressed value in the cycle after `re_i` is high. It is zero in the cycle after `re_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 8 | Byte offset of the register |
| wdata_i | input | 32 | Write data |
| we_i | input | 1 | Write strobe |
| re_i | input | 1 | Read strobe |
| rdata_o | output | 32 | Read data, registered |
| err_flag_i | input | NUM_CH | Per-channel error flags held by the engine |
| err_irq_o | output | NUM_CH | Per-channel error interrupt requests |
| err_irq_any_o | output | 1 | OR of all error interrupt requests |
| req_en_o | output | NUM_CH | Request-enable vector to the engine |

## Verification
The bench builds the block with `NUM_CH` = 40. The high registers are therefore only partly populated, which exercises the R11 boundary. A direct write of all ones to a high register must read back as 0x000000FF. Command values 40 to 63 name channels that do not exist. The global set must stop at bit 39. With this width the same run also covers the split between the two register halves and single-bit commands on both sides of it.

// File: rtl/dma_en_pkg.sv
package dma_en_pkg;
  localparam int unsigned ADDR_W = 8;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned VEC_W  = 64;

  localparam logic [ADDR_W-1:0] OFF_ERQ_HI = 8'h08;
  localparam logic [ADDR_W-1:0] OFF_ERQ_LO = 8'h0C;
  localparam logic [ADDR_W-1:0] OFF_EEI_HI = 8'h10;
  localparam logic [ADDR_W-1:0] OFF_EEI_LO = 8'h14;
  localparam logic [ADDR_W-1:0] OFF_SET    = 8'h18;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_ERQ_HI,
    SEL_ERQ_LO,
    SEL_EEI_HI,
    SEL_EEI_LO,
    SEL_SET
  } reg_sel_e;
endpackage

// File: rtl/dma_en_decode.sv
module dma_en_decode
  import dma_en_pkg::*;
(
  input  logic [ADDR_W-1:0] addr_i,
  output reg_sel_e          sel_o
);
  always_comb begin
    unique case (addr_i)
      OFF_ERQ_HI: sel_o = SEL_ERQ_HI;
      OFF_ERQ_LO: sel_o = SEL_ERQ_LO;
      OFF_EEI_HI: sel_o = SEL_EEI_HI;
      OFF_EEI_LO: sel_o = SEL_EEI_LO;
      OFF_SET:    sel_o = SEL_SET;
      default:    sel_o = SEL_NONE;
    endcase
  end
endmodule

// File: rtl/dma_set_cmd.sv
module dma_set_cmd #(
  parameter int unsigned NUM_CH = 64
) (
  input  logic              valid_i,
  input  logic [7:0]        cmd_i,
  output logic [NUM_CH-1:0] set_mask_o
);
  logic take;
  assign take = valid_i & ~cmd_i[7];

  // bit 6 selects the global set; bits 5:0 name a channel
  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    assign set_mask_o[ch] = take & (cmd_i[6] | (cmd_i[5:0] == 6'(ch)));
  end
endmodule

// File: rtl/dma_en_vec.sv
module dma_en_vec
  import dma_en_pkg::*;
#(
  parameter int unsigned NUM_CH = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_hi_i,
  input  logic              wr_lo_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [NUM_CH-1:0] set_i,
  output logic [NUM_CH-1:0] vec_o
);
  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_bit
    localparam bit IS_HI = (ch >= DATA_W);
    localparam int unsigned POS = IS_HI ? ch - DATA_W : ch;
    logic wr, d;
    assign wr = IS_HI ? wr_hi_i : wr_lo_i;
    // command set is applied after the direct write
    assign d  = (wr ? wdata_i[POS] : vec_o[ch]) | set_i[ch];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) vec_o[ch] <= 1'b0;
      else         vec_o[ch] <= d;
    end
  end
endmodule

// File: rtl/dma_err_gate.sv
module dma_err_gate #(
  parameter int unsigned NUM_CH = 64
) (
  input  logic [NUM_CH-1:0] flag_i,
  input  logic [NUM_CH-1:0] en_i,
  output logic [NUM_CH-1:0] irq_o,
  output logic              any_o
);
  assign irq_o = flag_i & en_i;
  assign any_o = |irq_o;
endmodule

// File: rtl/dma_en_bank.sv
module dma_en_bank
  import dma_en_pkg::*;
#(
  parameter int unsigned NUM_CH = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [7:0]        addr_i,
  input  logic [31:0]       wdata_i,
  input  logic              we_i,
  input  logic              re_i,
  output logic [31:0]       rdata_o,
  input  logic [NUM_CH-1:0] err_flag_i,
  output logic [NUM_CH-1:0] err_irq_o,
  output logic              err_irq_any_o,
  output logic [NUM_CH-1:0] req_en_o
);
  initial begin
    if (NUM_CH < 1 || NUM_CH > VEC_W) $error("NUM_CH out of range");
  end

  reg_sel_e          sel;
  logic [NUM_CH-1:0] set_mask, eei_vec;
  logic [VEC_W-1:0]  erq_ext, eei_ext;
  logic [DATA_W-1:0] rdata_d;

  dma_en_decode u_dec (.addr_i(addr_i), .sel_o(sel));

  dma_set_cmd #(.NUM_CH(NUM_CH)) u_cmd (
    .valid_i   (we_i && sel == SEL_SET),
    .cmd_i     (wdata_i[7:0]),
    .set_mask_o(set_mask)
  );

  dma_en_vec #(.NUM_CH(NUM_CH)) u_erq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_hi_i(we_i && sel == SEL_ERQ_HI),
    .wr_lo_i(we_i && sel == SEL_ERQ_LO),
    .wdata_i(wdata_i),
    .set_i  (set_mask),
    .vec_o  (req_en_o)
  );

  dma_en_vec #(.NUM_CH(NUM_CH)) u_eei (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_hi_i(we_i && sel == SEL_EEI_HI),
    .wr_lo_i(we_i && sel == SEL_EEI_LO),
    .wdata_i(wdata_i),
    .set_i  ('0),
    .vec_o  (eei_vec)
  );

  dma_err_gate #(.NUM_CH(NUM_CH)) u_gate (
    .flag_i(err_flag_i),
    .en_i  (eei_vec),
    .irq_o (err_irq_o),
    .any_o (err_irq_any_o)
  );

  assign erq_ext = VEC_W'(req_en_o);
  assign eei_ext = VEC_W'(eei_vec);

  always_comb begin
    unique case (sel)
      SEL_ERQ_HI: rdata_d = erq_ext[VEC_W-1:DATA_W];
      SEL_ERQ_LO: rdata_d = erq_ext[DATA_W-1:0];
      SEL_EEI_HI: rdata_d = eei_ext[VEC_W-1:DATA_W];
      SEL_EEI_LO: rdata_d = eei_ext[DATA_W-1:0];
      default:    rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_o <= '0;
    else         rdata_o <= re_i ? rdata_d : '0;
  end
endmodule

// File: rtl/dma_en_bank_chk.sv
module dma_en_bank_chk
  import dma_en_pkg::*;
#(
  parameter int unsigned NUM_CH = 64
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [7:0]        addr_i,
  input logic [31:0]       wdata_i,
  input logic              we_i,
  input logic              re_i,
  input logic [31:0]       rdata_o,
  input logic [NUM_CH-1:0] err_flag_i,
  input logic [NUM_CH-1:0] err_irq_o,
  input logic              err_irq_any_o,
  input logic [NUM_CH-1:0] req_en_o
);
  logic unmapped;
  assign unmapped = addr_i != OFF_ERQ_HI && addr_i != OFF_ERQ_LO && addr_i != OFF_EEI_HI
                 && addr_i != OFF_EEI_LO && addr_i != OFF_SET;

  a_r4_single_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == OFF_SET && wdata_i[7:6] == 2'b00) |=>
      ((req_en_o & $past(req_en_o)) == $past(req_en_o))
      && $countones(req_en_o ^ $past(req_en_o)) <= 1);

  a_r5_global_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == OFF_SET && wdata_i[7:6] == 2'b01) |=> (&req_en_o));

  a_r6_high_cmd_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == OFF_SET && wdata_i[7]) |=> $stable(req_en_o));

  a_r7_cmd_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && addr_i == OFF_SET) |=> rdata_o == '0);

  a_r8_irq_needs_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_irq_o & ~err_flag_i) == '0);

  a_r9_any_matches: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_irq_any_o == (|err_irq_o));

  a_r10_unmapped_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && unmapped) |=> $stable(req_en_o));

  a_r10_unmapped_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && unmapped) |=> rdata_o == '0);

  a_r12_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !re_i |=> rdata_o == '0);
endmodule

bind dma_en_bank dma_en_bank_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wdata_i(wdata_i),
  .we_i(we_i), .re_i(re_i), .rdata_o(rdata_o), .err_flag_i(err_flag_i),
  .err_irq_o(err_irq_o), .err_irq_any_o(err_irq_any_o), .req_en_o(req_en_o)
);

// File: tb/tb_dma_en_bank.sv
module tb_dma_en_bank;
  localparam int unsigned NCH = 40;
  localparam logic [63:0] IMPL = (64'd1 << NCH) - 64'd1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] addr = '0;
  logic [31:0] wdata = '0;
  logic we = 1'b0, re = 1'b0;
  logic [31:0] rdata;
  logic [NCH-1:0] flags = '0, irq, req_en;
  logic any;

  int checks = 0, fails = 0;
  logic [63:0] erq_m = '0, eei_m = '0;
  logic [31:0] exp_q[$];
  string tag_q[$];
  logic rd_done = 1'b0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  dma_en_bank #(.NUM_CH(NCH)) dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata), .we_i(we), .re_i(re),
    .rdata_o(rdata), .err_flag_i(flags), .err_irq_o(irq), .err_irq_any_o(any),
    .req_en_o(req_en)
  );

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: one result per completed read
  always @(posedge clk) rd_done <= re;
  always @(negedge clk) begin
    if (rd_done) begin
      if (exp_q.size() == 0) chk("R12 unexpected read data", 64'(rdata), 64'hx);
      else chk(tag_q.pop_front(), 64'(rdata), 64'(exp_q.pop_front()));
    end
  end

  function automatic logic [31:0] model_read(logic [7:0] a);
    case (a)
      8'h08: return erq_m[63:32];
      8'h0C: return erq_m[31:0];
      8'h10: return eei_m[63:32];
      8'h14: return eei_m[31:0];
      default: return '0;
    endcase
  endfunction

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    case (a)
      8'h08: erq_m[63:32] = d;
      8'h0C: erq_m[31:0]  = d;
      8'h10: eei_m[63:32] = d;
      8'h14: eei_m[31:0]  = d;
      8'h18: if (!d[7]) erq_m = erq_m | (d[6] ? 64'hFFFF_FFFF_FFFF_FFFF : (64'd1 << d[5:0]));
      default: ;
    endcase
    erq_m &= IMPL; eei_m &= IMPL;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, string tag);
    @(negedge clk);
    addr = a; re = 1'b1;
    exp_q.push_back(model_read(a));
    tag_q.push_back(tag);
    @(negedge clk);
    re = 1'b0;
  endtask

  task automatic rd_all(string tag);
    rd(8'h08, {tag, " erq_hi"});
    rd(8'h0C, {tag, " erq_lo"});
    rd(8'h10, {tag, " eei_hi"});
    rd(8'h14, {tag, " eei_lo"});
  endtask

  task automatic chk_irq(string tag);
    #1;
    chk({tag, " R8 irq"}, 64'(irq), 64'(flags) & eei_m);
    chk({tag, " R9 any"}, 64'(any), 64'(|(64'(flags) & eei_m)));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL R12 watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 req_en at reset", 64'(req_en), 64'd0);
    chk("R1 rdata at reset", 64'(rdata), 64'd0);
    rst_n = 1'b1;
    rd_all("R1 reset");

    // R2 / R11 direct writes
    wr(8'h0C, 32'hA5A5_0F0F);
    wr(8'h08, 32'hFFFF_FFFF);
    rd(8'h0C, "R2 erq_lo readback");
    rd(8'h08, "R11 erq_hi upper channels");
    chk("R2 req_en_o", 64'(req_en), erq_m);

    // R3
    wr(8'h14, 32'h1234_5678);
    wr(8'h10, 32'h0000_00C3);
    rd(8'h14, "R3 eei_lo readback");
    rd(8'h10, "R3 eei_hi readback");

    // R4 single set, R11 out-of-range channel
    wr(8'h08, 32'h0); wr(8'h0C, 32'h0);
    wr(8'h18, 32'd5);
    wr(8'h18, 32'd37);
    wr(8'h18, 32'hFFFF_FF03);
    chk("R4 single sets", 64'(req_en), erq_m);
    wr(8'h18, 32'd50);
    chk("R11 cmd beyond NUM_CH", 64'(req_en), erq_m);
    rd_all("R4");

    // R6 ignored commands
    wr(8'h18, 32'h85);
    wr(8'h18, 32'hC0);
    wr(8'h18, 32'hFF);
    chk("R6 bit7 cmds ignored", 64'(req_en), erq_m);

    // R5 global sets
    wr(8'h18, 32'd64);
    chk("R5 global set 64", 64'(req_en), IMPL);
    wr(8'h08, 32'h0); wr(8'h0C, 32'h0);
    wr(8'h18, 32'd127);
    chk("R5 global set 127", 64'(req_en), IMPL);
    rd_all("R5");

    // R7
    rd(8'h18, "R7 cmd read zero");

    // R10 unmapped
    wr(8'h00, 32'hFFFF_FFFF);
    wr(8'h1C, 32'hFFFF_FFFF);
    wr(8'h0D, 32'h0);
    chk("R10 unmapped write", 64'(req_en), erq_m);
    rd(8'h00, "R10 read 0x00");
    rd(8'h1C, "R10 read 0x1C");
    rd_all("R10 state kept");

    // R12 idle read data
    repeat (2) @(negedge clk);
    chk("R12 idle rdata", 64'(rdata), 64'd0);

    // R8 / R9 interrupt gating
    wr(8'h14, 32'h0); wr(8'h10, 32'h0);
    flags = '1; chk_irq("no enables");
    wr(8'h14, 32'h8000_0001); wr(8'h10, 32'h0000_0080);
    flags = '0; chk_irq("no flags");
    flags = 40'h00_0000_0001; chk_irq("ch0");
    flags = 40'h80_0000_0000; chk_irq("ch39");
    flags = 40'h7F_7FFF_FFFE; chk_irq("disabled flags");
    flags = '1; chk_irq("all flags");

    repeat (4) @(negedge clk);
    chk("R12 queue drained", 64'(exp_q.size()), 64'd0);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule